// File: doc/BRIEF.md
# PWM Interrupt Controller

This block gathers the two interrupt events of a PWM timer, the start-of-period sync pulse and the protection trip, into one level-sensitive interrupt line. Each source has a pending bit that stays set until software acknowledges it. Each source also has a separate sticky status bit that records that the source has fired at least once since reset.

Software configures the block through write strobes with data: a one-bit global enable, a per-source enable mask and a per-source acknowledge mask. Pending and sticky bits are presented as read-back values. The interrupt line is raised only when the global enable is set and at least one pending source is individually enabled. Pending and sticky bits record events whatever the enables are, so masking never loses an event.

Top module: `pwm_irq_ctrl`

## Requirements
- R1: After reset, pending, sticky status, the global enable and both source enables are 0, and the interrupt line is low.
- R2: An event pulse on a source sets that source's pending bit on the next clock edge, whatever the enables are. Bit 0 of every mask is the sync source and bit 1 is the trip source.
- R3: An acknowledge write clears each pending bit whose acknowledge data bit is 1. Pending bits whose data bit is 0 keep their value.
- R4: When an event and an acknowledge of the same source fall in the same cycle, the pending bit stays set.
- R5: A sticky status bit sets on its source's event. Acknowledge does not clear it. Only reset clears it.
- R6: The interrupt line equals the global enable ANDed with the OR over sources of (pending AND source enable).
- R7: A global enable write takes data bit 0 (1 enables, 0 disables). With the global enable at 0 the line is low, and pending bits are kept.
- R8: A source enable write loads the mask. A source whose enable bit is 0 does not raise the line, while other enabled pending sources still do.
- R9: Register writes and events change the outputs on the clock edge that samples them, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 2 | One-cycle event pulses (bit 0 sync, bit 1 trip) |
| gen_wr_i | input | 1 | Global enable write strobe |
| gen_wdata_i | input | 1 | Global enable write data |
| en_wr_i | input | 1 | Source enable write strobe |
| en_wdata_i | input | 2 | Source enable write data |
| ack_wr_i | input | 1 | Acknowledge write strobe |
| ack_wdata_i | input | 2 | Acknowledge mask, 1 clears pending |
| irq_o | output | 1 | Level interrupt line |
| pend_o | output | 2 | Pending read-back |
| sticky_o | output | 2 | Sticky status read-back |

## Verification
Every result is due one cycle after its stimulus. Pending, sticky and the enables are registers, and the line is built from those registers alone, so an input driven in one cycle shows up after the next rising edge. The driver applies each stimulus just after a falling edge and queues the expected outputs after the rising edge that captures it. The monitor compares at the following falling edge, so no sample falls on an edge.

// File: rtl/pwm_irq_ctrl.sv
module pwm_irq_ctrl #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            gen_wr_i,
  input  logic            gen_wdata_i,
  input  logic            en_wr_i,
  input  logic [NSRC-1:0] en_wdata_i,
  input  logic            ack_wr_i,
  input  logic [NSRC-1:0] ack_wdata_i,
  output logic            irq_o,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] sticky_o
);

  logic            gen_q;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] clr;

  assign clr = ack_wr_i ? ack_wdata_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q <= 1'b0;
      en_q  <= '0;
    end else begin
      if (gen_wr_i) gen_q <= gen_wdata_i;
      if (en_wr_i)  en_q  <= en_wdata_i;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_o[i]   <= 1'b0;
        sticky_o[i] <= 1'b0;
      end else begin
        pend_o[i]   <= evt_i[i] | (pend_o[i] & ~clr[i]);
        sticky_o[i] <= sticky_o[i] | evt_i[i];
      end
    end

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> pend_o[i]);
    p_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr_i && ack_wdata_i[i] && !evt_i[i]) |=> !pend_o[i]);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[i] && !clr[i]) |=> pend_o[i]);
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sticky_o[i] |=> sticky_o[i]);
    p_pend_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o[i] |-> sticky_o[i]);
  end

  assign irq_o = gen_q & |(pend_o & en_q);

  p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |pend_o);
  p_gen_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_wr_i && !gen_wdata_i) |=> !irq_o);
  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_i && en_wdata_i == '0) |=> !irq_o);

endmodule

// File: tb/pwm_irq_ctrl_bench.sv
module pwm_irq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] evt = '0;
  logic gen_wr = 0, gen_wd = 0, en_wr = 0, ack_wr = 0;
  logic [1:0] en_wd = '0, ack_wd = '0;
  logic irq;
  logic [1:0] pend, sticky;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic       irq;
    logic [1:0] pend;
    logic [1:0] sticky;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic m_gen = 0;
  logic [1:0] m_en = '0, m_pend = '0, m_sticky = '0;

  always #5 clk = ~clk;

  pwm_irq_ctrl u_pwm_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .gen_wr_i(gen_wr), .gen_wdata_i(gen_wd),
    .en_wr_i(en_wr), .en_wdata_i(en_wd),
    .ack_wr_i(ack_wr), .ack_wdata_i(ack_wd),
    .irq_o(irq), .pend_o(pend), .sticky_o(sticky)
  );

  task automatic cmp(input exp_t e);
    checks++;
    if (irq !== e.irq || pend !== e.pend || sticky !== e.sticky) begin
      errors++;
      $display("FAIL %s: irq/pend/sticky got %b/%b/%b expected %b/%b/%b",
               e.tag, irq, pend, sticky, e.irq, e.pend, e.sticky);
    end
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) cmp(q.pop_front());
  end

  // driver: called just after a falling edge
  task automatic step(input logic [1:0] ev, input logic gw, input logic gd,
                      input logic ew, input logic [1:0] ed,
                      input logic aw, input logic [1:0] ad, input string tag);
    exp_t e;
    evt = ev; gen_wr = gw; gen_wd = gd; en_wr = ew; en_wd = ed;
    ack_wr = aw; ack_wd = ad;
    @(posedge clk);
    if (gw) m_gen = gd;
    if (ew) m_en = ed;
    m_pend = (m_pend & ~(aw ? ad : 2'b00)) | ev;
    m_sticky = m_sticky | ev;
    e.irq = m_gen & |(m_pend & m_en);
    e.pend = m_pend;
    e.sticky = m_sticky;
    e.tag = tag;
    #1 q.push_back(e);
    @(negedge clk);
    evt = '0; gen_wr = 0; en_wr = 0; ack_wr = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    begin
      exp_t r;
      r.irq = 0; r.pend = 0; r.sticky = 0; r.tag = "R1 reset";
      cmp(r);
    end
    rst_n = 1'b1;
    step(2'b01, 0, 0, 0, 2'b00, 0, 2'b00, "R2 sync event, enables off");
    step(2'b00, 1, 1, 0, 2'b00, 0, 2'b00, "R8 global on, source masked");
    step(2'b00, 0, 0, 1, 2'b01, 0, 2'b00, "R6 R9 sync enabled raises line");
    step(2'b10, 0, 0, 0, 2'b00, 0, 2'b00, "R2 trip event");
    step(2'b00, 0, 0, 0, 2'b00, 1, 2'b01, "R3 R8 ack sync, trip masked");
    step(2'b00, 0, 0, 1, 2'b10, 0, 2'b00, "R6 trip enabled");
    step(2'b00, 1, 0, 0, 2'b00, 0, 2'b00, "R7 global off keeps pending");
    step(2'b00, 0, 0, 0, 2'b00, 1, 2'b00, "R3 ack with zero mask");
    step(2'b00, 1, 1, 0, 2'b00, 0, 2'b00, "R7 global on again");
    step(2'b10, 0, 0, 0, 2'b00, 1, 2'b10, "R4 trip event with its ack");
    step(2'b01, 0, 0, 0, 2'b00, 1, 2'b10, "R4 sync event, trip acked");
    step(2'b00, 0, 0, 0, 2'b00, 1, 2'b11, "R5 ack all, sticky stays");
    step(2'b11, 0, 0, 1, 2'b11, 0, 2'b00, "R6 both events both enabled");
    step(2'b00, 0, 0, 1, 2'b00, 0, 2'b00, "R8 all sources masked");
    step(2'b00, 0, 0, 0, 2'b00, 0, 2'b00, "R9 idle hold");
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    begin
      exp_t r;
      r.irq = 0; r.pend = 0; r.sticky = 0; r.tag = "R1 R5 reset clears sticky";
      cmp(r);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule